// File: doc/BRIEF.md
# Single-Adder Program Counter Sequencer

This block produces the instruction fetch address for a pipelined 32-bit core. All address arithmetic goes through one adder. One input of the adder is the current program counter. The other input is a two-way select between the fixed instruction step of 4 bytes and a sign-extended, word-scaled branch offset. The block does not build a separate branch-target adder. Instead, a taken branch is redirected two fetches after the delay slot.

The core raises `br_taken` together with a 16-bit word displacement in the cycle when the delay slot's address is on `fetch_addr`. The delay slot is already fetched and always runs. The next fetch, one word further on, is marked by `fetch_annul` and must have no architectural effect. During that annulled fetch the adder adds the stored offset to the annulled instruction's address, and the result becomes the following fetch address. `stall` freezes the whole sequencer. While it is high, no branch request is accepted.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values are `fetch_addr` = 0x00000000 and `fetch_annul` = 0.
- R2: A cycle with `stall` low, `fetch_annul` low and `br_taken` low moves `fetch_addr` to its current value plus 4 and keeps `fetch_annul` at 0.
- R3: A cycle with `stall` low, `fetch_annul` low and `br_taken` high accepts the branch. On the next cycle `fetch_addr` is the current value plus 4, and `fetch_annul` is 1 for that fetch.
- R4: In the cycle after an annulled fetch that is not stalled, `fetch_addr` equals the annulled fetch address plus the displacement captured when the branch was accepted. The displacement is interpreted as a signed word count, so the byte offset is the sign-extended `br_disp` shifted left by 2.
- R5: `fetch_annul` is high for exactly one non-stalled cycle per accepted branch, and it is low on the fetch that follows.
- R6: While `fetch_annul` is high, `br_taken` and `br_disp` have no effect.
- R7: While `stall` is high, `fetch_addr` and `fetch_annul` keep their values on the next cycle. `br_taken` is ignored in a stalled cycle.
- R8: A negative displacement (bit 15 of `br_disp` set) moves the address backwards, and the result wraps modulo 2^32.
- R9: Bits 1:0 of `fetch_addr` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds all state and blocks branch acceptance |
| br_taken | input | 1 | Taken-branch request, sampled while the delay slot address is on `fetch_addr` |
| br_disp | input | 16 | Signed branch displacement in words |
| fetch_addr | output | 32 | Current instruction fetch address |
| fetch_annul | output | 1 | The instruction at `fetch_addr` must be discarded |

## Verification
The bound checker tests the following properties on every cycle:
- the reset values;
- word alignment;
- the freeze under stall;
- the plus-4 step;
- that an accepted branch raises the annul flag;
- that the flag lasts a single fetch;
- the redirect sum.

The redirect sum is checked against a displacement that the checker captures for itself.

Other behaviours appear only in the bench scenarios:
- the wrap below address zero for a negative offset;
- that a request or a new displacement offered during the annulled fetch leaves the target unchanged;
- that a stall that lands on the annulled cycle postpones the redirect without losing it.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    parameter int unsigned XLEN_DEF   = 32;
    parameter int unsigned DISP_W_DEF = 16;
    parameter int unsigned STEP_DEF   = 4;

    typedef enum logic {
        ADD_STEP = 1'b0,
        ADD_DISP = 1'b1
    } addend_sel_e;

endpackage

// File: rtl/pc_addend_mux.sv
module pc_addend_mux
    import pc_seq_pkg::*;
#(
    parameter int unsigned XLEN   = XLEN_DEF,
    parameter int unsigned DISP_W = DISP_W_DEF,
    parameter int unsigned STEP   = STEP_DEF
) (
    input  addend_sel_e       sel,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   addend
);
    localparam int unsigned SH  = $clog2(STEP);
    localparam int unsigned EXT = XLEN - DISP_W - SH;

    logic [XLEN-1:0] disp_bytes;
    logic [XLEN-1:0] step_bytes;

    generate
        if (SH > 0) begin : g_scaled
            assign disp_bytes = {{EXT{disp[DISP_W-1]}}, disp, {SH{1'b0}}};
        end else begin : g_unscaled
            assign disp_bytes = {{EXT{disp[DISP_W-1]}}, disp};
        end
    endgenerate

    assign step_bytes = XLEN'(STEP);

    always_comb begin
        addend = (sel == ADD_DISP) ? disp_bytes : step_bytes;
    end

endmodule

// File: rtl/pc_adder.sv
module pc_adder #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] addend,
    output logic [XLEN-1:0] sum
);
    always_comb begin
        sum = base + addend;
    end
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pc_seq_pkg::*;
#(
    parameter int unsigned XLEN      = XLEN_DEF,
    parameter int unsigned DISP_W    = DISP_W_DEF,
    parameter int unsigned STEP      = STEP_DEF,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              br_taken,
    input  logic [DISP_W-1:0] br_disp,
    output logic [XLEN-1:0]   fetch_addr,
    output logic              fetch_annul
);
    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic              annul;
        logic [DISP_W-1:0] disp;
    } seq_state_t;

    localparam seq_state_t STATE_RST = '{
        pc:    XLEN'(RESET_VEC),
        annul: 1'b0,
        disp:  '0
    };

    seq_state_t  state_q;
    seq_state_t  state_d;
    addend_sel_e sel_d;
    logic [XLEN-1:0] addend_d;
    logic [XLEN-1:0] sum_d;

    // The annulled fetch is the slot in which the stored offset uses the adder.
    always_comb begin
        sel_d = state_q.annul ? ADD_DISP : ADD_STEP;
    end

    pc_addend_mux #(
        .XLEN   (XLEN),
        .DISP_W (DISP_W),
        .STEP   (STEP)
    ) i_addend_mux (
        .sel    (sel_d),
        .disp   (state_q.disp),
        .addend (addend_d)
    );

    pc_adder #(
        .XLEN (XLEN)
    ) i_adder (
        .base   (state_q.pc),
        .addend (addend_d),
        .sum    (sum_d)
    );

    always_comb begin
        state_d = state_q;
        if (!stall) begin
            state_d.pc = sum_d;
            if (state_q.annul) begin
                state_d.annul = 1'b0;
            end else if (br_taken) begin
                state_d.annul = 1'b1;
                state_d.disp  = br_disp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STATE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_addr  = state_q.pc;
    assign fetch_annul = state_q.annul;

endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned DISP_W = 16,
    parameter int unsigned STEP   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              br_taken,
    input logic [DISP_W-1:0] br_disp,
    input logic [XLEN-1:0]   fetch_addr,
    input logic              fetch_annul
);
    localparam int unsigned SH = $clog2(STEP);

    logic [DISP_W-1:0] seen_disp;
    logic [XLEN-1:0]   seen_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_disp <= '0;
        end else if (!stall && !fetch_annul && br_taken) begin
            seen_disp <= br_disp;
        end
    end

    assign seen_off = XLEN'($signed(seen_disp)) << SH;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !fetch_annul));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !fetch_annul && !br_taken)
            |=> (fetch_addr == $past(fetch_addr) + XLEN'(STEP) && !fetch_annul));

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (!stall && !fetch_annul && br_taken)
            |=> (fetch_annul && fetch_addr == $past(fetch_addr) + XLEN'(STEP)));

    p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        (!stall && fetch_annul)
            |=> (fetch_addr == $past(fetch_addr) + $past(seen_off)));

    p_single_annul_r5: assert property (@(posedge clk) disable iff (rst)
        (!stall && fetch_annul) |=> !fetch_annul);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_addr) && $stable(fetch_annul)));

    p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[SH-1:0] == '0);

endmodule

bind pc_seq_unit pc_seq_unit_chk #(
    .XLEN   (XLEN),
    .DISP_W (DISP_W),
    .STEP   (STEP)
) i_pc_seq_unit_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .br_taken    (br_taken),
    .br_disp     (br_disp),
    .fetch_addr  (fetch_addr),
    .fetch_annul (fetch_annul)
);

// File: tb/test_pc_seq_unit.sv
`timescale 1ns/1ps
module test_pc_seq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic        br_taken;
    logic [15:0] br_disp;
    logic [31:0] fetch_addr;
    logic        fetch_annul;

    int unsigned total = 0;
    int unsigned bad   = 0;
    bit          done  = 1'b0;

    logic [31:0] exp_pc;
    logic        exp_annul;
    logic [15:0] exp_disp;

    always #2.5 clk = ~clk;

    pc_seq_unit i_pc_seq_unit (
        .clk         (clk),
        .rst         (rst),
        .stall       (stall),
        .br_taken    (br_taken),
        .br_disp     (br_disp),
        .fetch_addr  (fetch_addr),
        .fetch_annul (fetch_annul)
    );

    function automatic logic [31:0] byte_off(input logic [15:0] d);
        return {{14{d[15]}}, d, 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic t, input logic [15:0] d);
        string tag_pc;
        string tag_an;
        stall    = s;
        br_taken = t;
        br_disp  = d;
        if (s) begin
            tag_pc = "R7";
            tag_an = "R7";
        end else if (exp_annul) begin
            tag_pc = exp_disp[15] ? "R8" : (t ? "R6" : "R4");
            tag_an = "R5";
            exp_pc    = exp_pc + byte_off(exp_disp);
            exp_annul = 1'b0;
        end else begin
            tag_pc = t ? "R3" : "R2";
            tag_an = t ? "R3" : "R2";
            exp_pc = exp_pc + 32'd4;
            if (t) begin
                exp_annul = 1'b1;
                exp_disp  = d;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(fetch_addr == exp_pc, tag_pc, fetch_addr, exp_pc);
        check(fetch_annul == exp_annul, tag_an, {31'd0, fetch_annul}, {31'd0, exp_annul});
        check(fetch_addr[1:0] == 2'b00, "R9", {30'd0, fetch_addr[1:0]}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; stall = 1'b0; br_taken = 1'b1; br_disp = 16'h7FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with a branch request present
        check(fetch_addr == 32'h0, "R1", fetch_addr, 32'h0);
        check(fetch_annul == 1'b0, "R1", {31'd0, fetch_annul}, 32'd0);
        rst = 1'b0; br_taken = 1'b0;
        exp_pc = 32'h0; exp_annul = 1'b0; exp_disp = '0;

        // R2: plain stepping
        step(1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 16'h1234);
        step(1'b0, 1'b0, 16'h0000);
        // R3/R8: backward branch that wraps below zero
        step(1'b0, 1'b1, 16'hFFF8);
        // R6: new request and new displacement during the annulled fetch
        step(1'b0, 1'b1, 16'h0100);
        step(1'b0, 1'b0, 16'h0000);
        // R7: taken under stall is ignored
        step(1'b1, 1'b1, 16'h0040);
        step(1'b1, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 16'h0000);
        // R4/R7: stall landing on the annulled cycle delays the redirect
        step(1'b0, 1'b1, 16'h0010);
        step(1'b1, 1'b0, 16'hAAAA);
        step(1'b1, 1'b1, 16'h5555);
        step(1'b0, 1'b0, 16'h0000);
        // R4: back-to-back accepted branches
        step(1'b0, 1'b1, 16'h0003);
        step(1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b1, 16'h8000);
        step(1'b0, 1'b0, 16'h0000);

        for (int i = 0; i < 3000; i++) begin
            logic s;
            logic t;
            s = ($urandom % 5) == 0;
            t = ($urandom % 4) == 0;
            step(s, t, 16'($urandom));
        end

        // R1: reset in the middle of a pending redirect
        step(1'b0, 1'b1, 16'h0020);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(fetch_addr == 32'h0, "R1", fetch_addr, 32'h0);
        check(fetch_annul == 1'b0, "R1", {31'd0, fetch_annul}, 32'd0);
        exp_pc = 32'h0; exp_annul = 1'b0;
        step(1'b0, 1'b0, 16'h0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule